// File: doc/BRIEF.md
# Dual-Bus Banked Memory Arbiter

This block sits between two core buses and four single-port on-chip SRAM banks. The primary bus carries data traffic. The secondary bus carries program-side and data traffic. A crossbar lets either bus reach any bank. When the two buses address different banks in the same cycle, both accesses go to their banks in that cycle. When both address the same bank, the primary bus wins that cycle. The secondary request is parked in a holding register and replayed in the next cycle. During that replay cycle the block raises `stall`, which tells the core to issue nothing.

Each request port is valid/ready. A request is taken on a rising clock edge where both `*_valid` and `*_ready` are high. While `*_ready` is low, the core must hold its request unchanged. A request presented during that time is not taken and has no effect on the banks. Both readies drop together, and only during a stall cycle. Read responses carry no back-pressure: a read yields exactly one `*_rsp_valid` pulse with its data, and the core must accept it in that cycle. Writes produce no response.

Top module: `dualbus_bank_arbiter`

## Requirements
- R1: Addresses are word addresses of `2 + log2(BANK_DEPTH)` bits. The bank is chosen by the top two address bits, which are bits [7:6] at the default depth of 64. The low bits give the word within the bank.
- R2: Either bus can write and read every word of every bank. Data written through one bus reads back unchanged through the other.
- R3: When both buses present accepted requests to different banks in one cycle, both complete in that cycle. Each read returns its data one cycle later, and `stall` stays low.
- R4: When both buses present accepted requests to the same bank, the primary access completes in that cycle and the secondary in the following cycle. `stall` is high for exactly that one following cycle. A secondary read's response arrives two cycles after acceptance.
- R5: While `stall` is high, both `pri_ready` and `sec_ready` are low. A request presented in that cycle changes no bank contents.
- R6: An access on only one bus never causes `stall`.
- R7: A read accepted on a bus raises that bus's `*_rsp_valid` for one cycle exactly one cycle later (except the deferred case in R4). An accepted write raises no response.
- R8: Within a same-bank conflict the primary access takes effect first. A primary read of the word the secondary writes returns the old value. A secondary read of the word the primary writes returns the new value.
- R9: Directly after reset, `stall` and both `*_rsp_valid` are low and both readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_valid | input | 1 | Primary request valid |
| pri_ready | output | 1 | Primary request accepted when high with valid |
| pri_we | input | 1 | Primary write (1) or read (0) |
| pri_addr | input | ADDR_W | Primary word address |
| pri_wdata | input | DATA_W | Primary write data |
| pri_rsp_valid | output | 1 | Primary read data valid |
| pri_rsp_data | output | DATA_W | Primary read data |
| sec_valid | input | 1 | Secondary request valid |
| sec_ready | output | 1 | Secondary request accepted when high with valid |
| sec_we | input | 1 | Secondary write (1) or read (0) |
| sec_addr | input | ADDR_W | Secondary word address |
| sec_wdata | input | DATA_W | Secondary write data |
| sec_rsp_valid | output | 1 | Secondary read data valid |
| sec_rsp_data | output | DATA_W | Secondary read data |
| stall | output | 1 | High in the cycle a deferred secondary access is replayed |

## Verification
The hardest case to reach from the ports is a request arriving in the replay cycle itself. The core would normally hold off, so the bench forces it. The bench sets up a same-bank write pair, then drives fresh writes during the stall cycle and withdraws them. It then reads the targeted words back to show they were untouched. Ordering inside a conflict is also directed: a read and a write share one word on opposite buses in both orientations. A long pseudo-random run then biases half of its pairs onto a shared bank. A scoreboard tracks the cycle in which each response is due.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  // who drives a bank port in the current cycle
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_PRI  = 2'd1,
    SRC_SEC  = 2'd2
  } bank_src_e;
endpackage

// File: rtl/dbm_sram_bank.sv
module dbm_sram_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem_q[off] <= wdata;
      else    rdata      <= mem_q[off];
    end
  end
endmodule

// File: rtl/dbm_issue_ctrl.sv
module dbm_issue_ctrl #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 6,
  parameter int BSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_valid,
  input  logic              pri_we,
  input  logic [BSEL_W-1:0] pri_bank,
  input  logic [OFF_W-1:0]  pri_off,
  input  logic [DATA_W-1:0] pri_wdata,
  input  logic              sec_valid,
  input  logic              sec_we,
  input  logic [BSEL_W-1:0] sec_bank,
  input  logic [OFF_W-1:0]  sec_off,
  input  logic [DATA_W-1:0] sec_wdata,
  output logic              pri_ready,
  output logic              sec_ready,
  output logic              stall,
  output logic              conflict,
  output logic              pri_go,
  output logic              sec_go,
  output logic              sec_go_we,
  output logic [BSEL_W-1:0] sec_go_bank,
  output logic [OFF_W-1:0]  sec_go_off,
  output logic [DATA_W-1:0] sec_go_wdata
);
  logic              park_q;
  logic              park_we_q;
  logic [BSEL_W-1:0] park_bank_q;
  logic [OFF_W-1:0]  park_off_q;
  logic [DATA_W-1:0] park_wdata_q;
  logic              pri_fire, sec_fire;

  assign stall     = park_q;
  assign pri_ready = !park_q;
  assign sec_ready = !park_q;
  assign pri_fire  = pri_valid && !park_q;
  assign sec_fire  = sec_valid && !park_q;
  assign conflict  = pri_fire && sec_fire && (pri_bank == sec_bank);

  assign pri_go       = pri_fire;
  assign sec_go       = park_q || (sec_fire && !conflict);
  assign sec_go_we    = park_q ? park_we_q    : sec_we;
  assign sec_go_bank  = park_q ? park_bank_q  : sec_bank;
  assign sec_go_off   = park_q ? park_off_q   : sec_off;
  assign sec_go_wdata = park_q ? park_wdata_q : sec_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) park_q <= 1'b0;
    else        park_q <= conflict;
  end

  always_ff @(posedge clk) begin
    if (conflict) begin
      park_we_q    <= sec_we;
      park_bank_q  <= sec_bank;
      park_off_q   <= sec_off;
      park_wdata_q <= sec_wdata;
    end
  end

  assert_stall_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  assert_conflict_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> stall);
  assert_lone_bus_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_valid != sec_valid) && !stall |=> !stall);
  assert_pri_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> pri_go && !sec_go);
endmodule

// File: rtl/dbm_xbar.sv
module dbm_xbar
  import dbm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 6,
  parameter int NUM_BANKS = 4,
  localparam int BSEL_W   = $clog2(NUM_BANKS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pri_go,
  input  logic                              pri_we,
  input  logic [BSEL_W-1:0]                 pri_bank,
  input  logic [OFF_W-1:0]                  pri_off,
  input  logic [DATA_W-1:0]                 pri_wdata,
  input  logic                              sec_go,
  input  logic                              sec_we,
  input  logic [BSEL_W-1:0]                 sec_bank,
  input  logic [OFF_W-1:0]                  sec_off,
  input  logic [DATA_W-1:0]                 sec_wdata,
  output logic [NUM_BANKS-1:0]              bank_en,
  output logic [NUM_BANKS-1:0]              bank_we,
  output logic [NUM_BANKS-1:0][OFF_W-1:0]   bank_off,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_wdata
);
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_port
    logic      pri_hit, sec_hit;
    bank_src_e src;

    assign pri_hit = pri_go && (pri_bank == BSEL_W'(k));
    assign sec_hit = sec_go && (sec_bank == BSEL_W'(k));

    always_comb begin
      if (pri_hit)      src = SRC_PRI;
      else if (sec_hit) src = SRC_SEC;
      else              src = SRC_IDLE;
    end

    always_comb begin
      unique case (src)
        SRC_PRI: begin
          bank_en[k]    = 1'b1;
          bank_we[k]    = pri_we;
          bank_off[k]   = pri_off;
          bank_wdata[k] = pri_wdata;
        end
        SRC_SEC: begin
          bank_en[k]    = 1'b1;
          bank_we[k]    = sec_we;
          bank_off[k]   = sec_off;
          bank_wdata[k] = sec_wdata;
        end
        default: begin
          bank_en[k]    = 1'b0;
          bank_we[k]    = 1'b0;
          bank_off[k]   = '0;
          bank_wdata[k] = '0;
        end
      endcase
    end

    // a single-port bank may only ever see one bus per cycle
    assert_bank_single_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pri_hit && sec_hit));
  end
endmodule

// File: rtl/dbm_rsp_path.sv
module dbm_rsp_path #(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  localparam int BSEL_W   = $clog2(NUM_BANKS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             go,
  input  logic                             we,
  input  logic [BSEL_W-1:0]                bank,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata,
  output logic                             rsp_valid,
  output logic [DATA_W-1:0]                rsp_data
);
  logic [BSEL_W-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      bank_q    <= '0;
    end else begin
      rsp_valid <= go && !we;
      if (go && !we) bank_q <= bank;
    end
  end

  assign rsp_data = bank_rdata[bank_q];

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go && !we |=> rsp_valid);
  assert_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go && we |=> !rsp_valid);
endmodule

// File: rtl/dualbus_bank_arbiter.sv
module dualbus_bank_arbiter #(
  parameter int DATA_W     = 32,
  parameter int BANK_DEPTH = 64,
  parameter int NUM_BANKS  = 4,
  localparam int OFF_W     = $clog2(BANK_DEPTH),
  localparam int BSEL_W    = $clog2(NUM_BANKS),
  localparam int ADDR_W    = OFF_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_valid,
  output logic              pri_ready,
  input  logic              pri_we,
  input  logic [ADDR_W-1:0] pri_addr,
  input  logic [DATA_W-1:0] pri_wdata,
  output logic              pri_rsp_valid,
  output logic [DATA_W-1:0] pri_rsp_data,
  input  logic              sec_valid,
  output logic              sec_ready,
  input  logic              sec_we,
  input  logic [ADDR_W-1:0] sec_addr,
  input  logic [DATA_W-1:0] sec_wdata,
  output logic              sec_rsp_valid,
  output logic [DATA_W-1:0] sec_rsp_data,
  output logic              stall
);
  // R1: bank index sits directly above the in-bank offset
  logic [BSEL_W-1:0] pri_bank, sec_bank;
  logic [OFF_W-1:0]  pri_off, sec_off;
  assign pri_bank = pri_addr[ADDR_W-1:OFF_W];
  assign pri_off  = pri_addr[OFF_W-1:0];
  assign sec_bank = sec_addr[ADDR_W-1:OFF_W];
  assign sec_off  = sec_addr[OFF_W-1:0];

  logic              conflict, pri_go, sec_go, sec_go_we;
  logic [BSEL_W-1:0] sec_go_bank;
  logic [OFF_W-1:0]  sec_go_off;
  logic [DATA_W-1:0] sec_go_wdata;

  dbm_issue_ctrl #(.DATA_W(DATA_W), .OFF_W(OFF_W), .BSEL_W(BSEL_W)) ctrl_i (
    .clk, .rst_n,
    .pri_valid, .pri_we, .pri_bank, .pri_off, .pri_wdata,
    .sec_valid, .sec_we, .sec_bank, .sec_off, .sec_wdata,
    .pri_ready, .sec_ready, .stall, .conflict,
    .pri_go, .sec_go, .sec_go_we, .sec_go_bank, .sec_go_off, .sec_go_wdata
  );

  logic [NUM_BANKS-1:0]             bank_en, bank_we;
  logic [NUM_BANKS-1:0][OFF_W-1:0]  bank_off;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_wdata, bank_rdata;

  dbm_xbar #(.DATA_W(DATA_W), .OFF_W(OFF_W), .NUM_BANKS(NUM_BANKS)) xbar_i (
    .clk, .rst_n,
    .pri_go, .pri_we, .pri_bank, .pri_off, .pri_wdata,
    .sec_go, .sec_we(sec_go_we), .sec_bank(sec_go_bank),
    .sec_off(sec_go_off), .sec_wdata(sec_go_wdata),
    .bank_en, .bank_we, .bank_off, .bank_wdata
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    dbm_sram_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) bank_i (
      .clk,
      .en   (bank_en[k]),
      .we   (bank_we[k]),
      .off  (bank_off[k]),
      .wdata(bank_wdata[k]),
      .rdata(bank_rdata[k])
    );
  end

  dbm_rsp_path #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) pri_rsp_i (
    .clk, .rst_n, .go(pri_go), .we(pri_we), .bank(pri_bank),
    .bank_rdata, .rsp_valid(pri_rsp_valid), .rsp_data(pri_rsp_data)
  );

  dbm_rsp_path #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) sec_rsp_i (
    .clk, .rst_n, .go(sec_go), .we(sec_go_we), .bank(sec_go_bank),
    .bank_rdata, .rsp_valid(sec_rsp_valid), .rsp_data(sec_rsp_data)
  );

  assert_split_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pri_valid && sec_valid && !stall && (pri_bank != sec_bank) |=> !stall);
  assert_deferred_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pri_valid && sec_valid && !stall && !sec_we && (pri_bank == sec_bank)
      |=> !sec_rsp_valid ##1 sec_rsp_valid);
endmodule

// File: tb/dualbus_bank_arbiter_tb_top.sv
module dualbus_bank_arbiter_tb_top;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          pri_valid = 0, pri_we = 0, sec_valid = 0, sec_we = 0;
  logic [AW-1:0] pri_addr = '0, sec_addr = '0;
  logic [DW-1:0] pri_wdata = '0, sec_wdata = '0;
  logic          pri_ready, sec_ready, pri_rsp_valid, sec_rsp_valid, stall;
  logic [DW-1:0] pri_rsp_data, sec_rsp_data;

  dualbus_bank_arbiter dut_i (
    .clk, .rst_n,
    .pri_valid, .pri_ready, .pri_we, .pri_addr, .pri_wdata,
    .pri_rsp_valid, .pri_rsp_data,
    .sec_valid, .sec_ready, .sec_we, .sec_addr, .sec_wdata,
    .sec_rsp_valid, .sec_rsp_data,
    .stall
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] model [256];
  logic [DW-1:0] qa_dat[$], qb_dat[$];
  int            qa_cyc[$], qb_cyc[$];
  string         qa_tag[$], qb_tag[$];

  function automatic void check(input bit ok, input string tag, input string what,
                                input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  // scoreboard monitor: compare each response against the queued expectation
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (pri_rsp_valid) begin
        if (qa_dat.size() == 0) check(0, "R7", "unexpected primary response", pri_rsp_data, '0);
        else begin
          check(pri_rsp_data === qa_dat[0], qa_tag[0], "primary data", pri_rsp_data, qa_dat[0]);
          check(cyc == qa_cyc[0], qa_tag[0], "primary timing", cyc, qa_cyc[0]);
          void'(qa_dat.pop_front()); void'(qa_cyc.pop_front()); void'(qa_tag.pop_front());
        end
      end
      if (sec_rsp_valid) begin
        if (qb_dat.size() == 0) check(0, "R7", "unexpected secondary response", sec_rsp_data, '0);
        else begin
          check(sec_rsp_data === qb_dat[0], qb_tag[0], "secondary data", sec_rsp_data, qb_dat[0]);
          check(cyc == qb_cyc[0], qb_tag[0], "secondary timing", cyc, qb_cyc[0]);
          void'(qb_dat.pop_front()); void'(qb_cyc.pop_front()); void'(qb_tag.pop_front());
        end
      end
    end
  end

  // driver: issue one cycle's pair, update the model, queue expectations
  task automatic issue(input bit av, input bit aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                       input bit bv, input bit bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                       input string tag);
    bit clash;
    int k;
    @(negedge clk);
    pri_valid = av; pri_we = aw; pri_addr = aa; pri_wdata = ad;
    sec_valid = bv; sec_we = bw; sec_addr = ba; sec_wdata = bd;
    while (stall) @(negedge clk);
    k = cyc;
    clash = av && bv && (aa[7:6] == ba[7:6]);  // R1: bank = addr[7:6]
    if (av) begin
      if (aw) model[aa] = ad;
      else begin qa_dat.push_back(model[aa]); qa_cyc.push_back(k + 1); qa_tag.push_back(tag); end
    end
    if (bv) begin
      if (bw) model[ba] = bd;
      else begin qb_dat.push_back(model[ba]); qb_cyc.push_back(clash ? k + 2 : k + 1); qb_tag.push_back(tag); end
    end
    @(negedge clk);
    pri_valid = 0; sec_valid = 0;
    check(stall === clash, clash ? "R4" : (av && bv ? "R3" : "R6"), "stall after accept", stall, clash);
    if (clash) begin
      @(negedge clk);
      check(stall === 1'b0, "R4", "stall lasts one cycle", stall, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(stall === 0 && pri_rsp_valid === 0 && sec_rsp_valid === 0, "R9", "reset outputs",
          {stall, pri_rsp_valid, sec_rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(pri_ready === 1 && sec_ready === 1 && stall === 0, "R9", "ready after reset",
          {pri_ready, sec_ready, stall}, 3'b110);

    // R2/R3: fill all words, primary low half, secondary high half (different banks)
    for (int i = 0; i < 128; i++)
      issue(1, 1, AW'(i), 32'hA000_0000 + i, 1, 1, AW'(i + 128), 32'hB000_0000 + i, "R3");
    // R2: read back crossed: primary reads secondary's words and vice versa
    for (int i = 0; i < 128; i += 7)
      issue(1, 0, AW'(i + 128), '0, 1, 0, AW'(i), '0, "R2");

    // R6: lone accesses
    issue(1, 0, 8'h05, '0, 0, 0, '0, '0, "R6");
    issue(0, 0, '0, '0, 1, 0, 8'hC5, '0, "R6");
    issue(1, 1, 8'h44, 32'h1234_5678, 0, 0, '0, '0, "R6");
    issue(0, 0, '0, '0, 1, 0, 8'h44, '0, "R7");

    // R4: same-bank reads on each bank
    for (int b = 0; b < 4; b++)
      issue(1, 0, AW'(b * 64 + 3), '0, 1, 0, AW'(b * 64 + 9), '0, "R4");

    // R8: ordering inside a conflict on one word
    issue(1, 0, 8'h50, '0, 1, 1, 8'h50, 32'hDEAD_0001, "R8");   // primary sees old
    issue(0, 0, '0, '0, 1, 0, 8'h50, '0, "R8");
    issue(1, 1, 8'h91, 32'hBEEF_0002, 1, 0, 8'h91, '0, "R8");   // secondary sees new
    issue(1, 1, 8'hE0, 32'h1111_1111, 1, 1, 8'hE0, 32'h2222_2222, "R8");
    issue(1, 0, 8'hE0, '0, 0, 0, '0, '0, "R8");

    // R5: requests forced in the stall cycle are not taken
    @(negedge clk);
    pri_valid = 1; pri_we = 1; pri_addr = 8'h70; pri_wdata = 32'h0B0B_0001;
    sec_valid = 1; sec_we = 1; sec_addr = 8'h7A; sec_wdata = 32'h0B0B_0002;
    model[8'h70] = 32'h0B0B_0001; model[8'h7A] = 32'h0B0B_0002;
    @(negedge clk);
    check(stall === 1 && pri_ready === 0 && sec_ready === 0, "R5", "readies low in stall",
          {stall, pri_ready, sec_ready}, 3'b100);
    pri_addr = 8'h10; pri_wdata = 32'hFFFF_0000;
    sec_addr = 8'hD0; sec_wdata = 32'hFFFF_0001;
    @(negedge clk);
    pri_valid = 0; sec_valid = 0;
    issue(1, 0, 8'h10, '0, 1, 0, 8'hD0, '0, "R5");
    issue(1, 0, 8'h7A, '0, 1, 0, 8'h70, '0, "R5");

    // mixed pseudo-random traffic, half the pairs forced onto one bank
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a1, a2;
      bit v1, v2, w1, w2;
      a1 = AW'($urandom); a2 = AW'($urandom);
      if ($urandom % 2) a2[7:6] = a1[7:6];
      v1 = ($urandom % 4) != 0; v2 = ($urandom % 4) != 0;
      w1 = $urandom % 2; w2 = $urandom % 2;
      issue(v1, w1, a1, $urandom, v2, w2, a2, $urandom,
            (v1 && v2) ? ((a1[7:6] == a2[7:6]) ? "R4" : "R3") : "R6");
    end

    repeat (4) @(negedge clk);
    check(qa_dat.size() == 0 && qb_dat.size() == 0, "R7", "all responses delivered",
          qa_dat.size() + qb_dat.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule